// File: doc/BRIEF.md
# Supercell Occupancy Peak-Hold Reducer

This block folds the per-tick segment weights of every cell in one supercell (three to eight cells) into one occupancy bit per tick. Each clock cycle is one tick. The first non-zero weight opens a fixed observation window. During the window the block holds the largest weight seen so far and marks every cell whose weight equals it. A strictly larger weight throws away the marks made so far and opens a fresh window from its own tick.

When the window closes, the marked hits are replayed as per-cell enables. Each enable keeps its tick offset relative to the window start. The enables are also ORed into a single occupancy bit for the downstream track linker. The block then returns to idle, and the next non-zero weight opens a new window. A new window can open on the very next tick, while the previous replay is still streaming out, so the block has no dead time.

Weights use a 2-bit code in which a larger value means a better segment: 0 means no segment, 1 a low-quality segment, 2 a three-layer segment and 3 a four-layer segment.

Top module: `supercell_peak_reducer`

## Requirements
- R1: While `rst_ni` is low and for the whole window length after its release, `en_o` and `occ_o` are zero. A window that was open when reset was asserted produces no enables.
- R2: A lone non-zero weight on cell c, sampled at clock edge s, yields `en_o[c]` high for exactly one cycle, following edge s+WAIT_TICKS (default 6).
- R3: `occ_o` is high in exactly those cycles in which at least one bit of `en_o` is high.
- R4: Within an open window, every later tick in which a cell's weight equals the held weight is recorded. It is replayed with the same tick spacing it had at the input. The last tick of the window (edge s+WAIT_TICKS) is included.
- R5: Non-zero weights below the held weight that arrive during an open window produce no enable.
- R6: A weight strictly above the held weight arriving during a window discards all earlier recordings, including at the window's last tick. The window then restarts with WAIT_TICKS counted from that tick.
- R7: After a window closes, a non-zero weight on the next tick opens a separate window, even if it is lower. Both windows are reported, and each keeps its own timing.
- R8: When several cells carry the maximum weight in the same tick, all of them are enabled in the same output cycle. Cells with lower weights in that tick are not enabled.
- R9: All-zero input never opens a window and never produces an enable.
- R10: Cell c's weight sits at bits [2c+1:2c] of `weights_i`, and `en_o[c]` reports cell c. Weights are compared as unsigned numbers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock; one weight sample per cell per edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| weights_i | input | N_CELLS*2 | Packed 2-bit weight per cell |
| en_o | output | N_CELLS | Delayed per-cell segment enables |
| occ_o | output | 1 | Supercell occupancy bit |

## Verification
The assertions take for granted that every input sample is a defined 2-bit code that is captured once per clock. They also assume that enables are only judged once the checker has seen WAIT_TICKS+1 edges since reset, so that each output cycle can be traced back to the input tick it reports. The stimulus drives weights on the falling edge only and holds them over the rising edge. After a reset it lets the full window length elapse before any enable is expected. Windows in the scripted run are spaced so that each expected enable belongs to exactly one window, except in the back-to-back and last-tick restart cases, which test that boundary on purpose.

// File: rtl/scr_pkg.sv
package scr_pkg;
  localparam int unsigned WT_BITS = 2;

  typedef enum logic [WT_BITS-1:0] {
    WT_NONE  = 2'd0,
    WT_LOWQ  = 2'd1,
    WT_THREE = 2'd2,
    WT_FOUR  = 2'd3
  } wt_e;

  typedef logic [WT_BITS-1:0] wt_t;
endpackage

// File: rtl/scr_peak_find.sv
module scr_peak_find
  import scr_pkg::*;
#(
  parameter int unsigned N_CELLS = 8
) (
  input  logic [N_CELLS*WT_BITS-1:0] weights_i,
  output wt_t                        peak_o,
  output logic [N_CELLS-1:0]         hit_o
);

  wt_t cell_w [N_CELLS];

  for (genvar c = 0; c < N_CELLS; c++) begin : g_unpack
    assign cell_w[c] = weights_i[c*WT_BITS +: WT_BITS];
  end

  always_comb begin
    peak_o = WT_NONE;
    for (int c = 0; c < N_CELLS; c++) begin
      if (cell_w[c] > peak_o) peak_o = cell_w[c];
    end
  end

  for (genvar c = 0; c < N_CELLS; c++) begin : g_hit
    assign hit_o[c] = (peak_o != WT_NONE) && (cell_w[c] == peak_o);
  end

endmodule

// File: rtl/scr_window_ctrl.sv
module scr_window_ctrl
  import scr_pkg::*;
#(
  parameter int unsigned WAIT_TICKS = 6,
  localparam int unsigned IDX_W     = $clog2(WAIT_TICKS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  wt_t              peak_i,
  output logic             start_o,
  output logic             rec_o,
  output logic [IDX_W-1:0] idx_o,
  output logic             done_o
);

  logic             active_q;
  wt_t              held_q;
  logic [IDX_W-1:0] cnt_q;

  logic nonzero, higher, equal;

  always_comb begin
    nonzero = (peak_i != WT_NONE);
    higher  = (peak_i > held_q);
    equal   = (peak_i == held_q);
    // idle: any hit opens; active: only a larger weight reopens
    start_o = nonzero && (!active_q || higher);
    rec_o   = start_o || (active_q && nonzero && equal);
    idx_o   = start_o ? '0 : cnt_q + IDX_W'(1);
    done_o  = active_q && !start_o && (cnt_q == IDX_W'(WAIT_TICKS - 1));
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      active_q <= 1'b0;
      held_q   <= WT_NONE;
      cnt_q    <= '0;
    end else if (start_o) begin
      active_q <= 1'b1;
      held_q   <= peak_i;
      cnt_q    <= '0;
    end else if (done_o) begin
      active_q <= 1'b0;
      held_q   <= WT_NONE;
      cnt_q    <= '0;
    end else if (active_q) begin
      cnt_q    <= cnt_q + IDX_W'(1);
    end
  end

endmodule

// File: rtl/scr_replay.sv
module scr_replay #(
  parameter int unsigned N_CELLS  = 8,
  parameter int unsigned DEPTH    = 7,
  localparam int unsigned IDX_W   = $clog2(DEPTH)
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               clr_i,
  input  logic               wr_i,
  input  logic [IDX_W-1:0]   idx_i,
  input  logic [N_CELLS-1:0] hit_i,
  input  logic               load_i,
  output logic [N_CELLS-1:0] en_o,
  output logic               occ_o
);

  logic [N_CELLS-1:0] rec_q [DEPTH];
  logic [N_CELLS-1:0] rec_n [DEPTH];
  logic [N_CELLS-1:0] rep_q [DEPTH];
  logic [N_CELLS-1:0] rep_n [DEPTH];
  logic               occ_q;

  // record store, slot k = tick k of the open window
  always_comb begin
    for (int k = 0; k < DEPTH; k++) begin
      rec_n[k] = clr_i ? '0 : rec_q[k];
      if (wr_i && (idx_i == IDX_W'(k))) rec_n[k] = hit_i;
    end
  end

  // replay line, slot 0 is presented on en_o
  for (genvar k = 0; k < DEPTH; k++) begin : g_rep
    if (k == DEPTH - 1) begin : g_top
      assign rep_n[k] = load_i ? rec_n[k] : '0;
    end else begin : g_mid
      assign rep_n[k] = load_i ? rec_n[k] : rep_q[k+1];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) begin
        rec_q[k] <= '0;
        rep_q[k] <= '0;
      end
      occ_q <= 1'b0;
    end else begin
      for (int k = 0; k < DEPTH; k++) begin
        rec_q[k] <= load_i ? '0 : rec_n[k];
        rep_q[k] <= rep_n[k];
      end
      occ_q <= |rep_n[0];
    end
  end

  assign en_o  = rep_q[0];
  assign occ_o = occ_q;

endmodule

// File: rtl/supercell_peak_reducer.sv
module supercell_peak_reducer
  import scr_pkg::*;
#(
  parameter int unsigned N_CELLS    = 8,
  parameter int unsigned WAIT_TICKS = 6
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [N_CELLS*WT_BITS-1:0] weights_i,
  output logic [N_CELLS-1:0]         en_o,
  output logic                       occ_o
);

  localparam int unsigned DEPTH = WAIT_TICKS + 1;
  localparam int unsigned IDX_W = $clog2(DEPTH);

  wt_t                peak;
  logic [N_CELLS-1:0] hit;
  logic               start, rec, done;
  logic [IDX_W-1:0]   idx;

  scr_peak_find #(.N_CELLS(N_CELLS)) u_peak (
    .weights_i (weights_i),
    .peak_o    (peak),
    .hit_o     (hit)
  );

  scr_window_ctrl #(.WAIT_TICKS(WAIT_TICKS)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .peak_i  (peak),
    .start_o (start),
    .rec_o   (rec),
    .idx_o   (idx),
    .done_o  (done)
  );

  scr_replay #(.N_CELLS(N_CELLS), .DEPTH(DEPTH)) u_rep (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .clr_i  (start),
    .wr_i   (rec),
    .idx_i  (idx),
    .hit_i  (hit),
    .load_i (done),
    .en_o   (en_o),
    .occ_o  (occ_o)
  );

endmodule

// File: rtl/scr_checker.sv
module scr_checker
  import scr_pkg::*;
#(
  parameter int unsigned N_CELLS    = 8,
  parameter int unsigned WAIT_TICKS = 6,
  localparam int unsigned FILL_W    = $clog2(WAIT_TICKS + 3)
) (
  input logic                       clk_i,
  input logic                       rst_ni,
  input logic [N_CELLS*WT_BITS-1:0] weights_i,
  input logic [N_CELLS-1:0]         en_o,
  input logic                       occ_o
);

  logic [N_CELLS*WT_BITS-1:0] dly_q [WAIT_TICKS+1];
  logic [FILL_W-1:0]          fill_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k <= WAIT_TICKS; k++) dly_q[k] <= '0;
      fill_q <= '0;
    end else begin
      dly_q[0] <= weights_i;
      for (int k = 1; k <= WAIT_TICKS; k++) dly_q[k] <= dly_q[k-1];
      if (fill_q <= FILL_W'(WAIT_TICKS)) fill_q <= fill_q + FILL_W'(1);
    end
  end

  // weights of the input tick that the current en_o reports
  wt_t  old_w [N_CELLS];
  wt_t  old_max;
  logic no_src, off_peak;

  always_comb begin
    old_max  = WT_NONE;
    no_src   = 1'b0;
    off_peak = 1'b0;
    for (int c = 0; c < N_CELLS; c++) begin
      old_w[c] = dly_q[WAIT_TICKS][c*WT_BITS +: WT_BITS];
      if (old_w[c] > old_max) old_max = old_w[c];
    end
    for (int c = 0; c < N_CELLS; c++) begin
      if (en_o[c] && old_w[c] == WT_NONE) no_src = 1'b1;
      if (en_o[c] && old_w[c] != old_max) off_peak = 1'b1;
    end
  end

  AST_QUIET_AFTER_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_q < FILL_W'(WAIT_TICKS)) |-> (en_o == '0 && !occ_o)); // R1

  AST_EN_NEEDS_HIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_q > FILL_W'(WAIT_TICKS)) |-> !no_src); // R2

  AST_OCC_TRACKS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    occ_o == (en_o != '0)); // R3

  AST_EN_AT_PEAK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fill_q > FILL_W'(WAIT_TICKS)) |-> !off_peak); // R8

endmodule

bind supercell_peak_reducer scr_checker #(
  .N_CELLS    (N_CELLS),
  .WAIT_TICKS (WAIT_TICKS)
) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .weights_i (weights_i),
  .en_o      (en_o),
  .occ_o     (occ_o)
);

// File: tb/sim_supercell_peak_reducer.sv
module sim_supercell_peak_reducer;

  localparam int N = 8;
  localparam int ROWS = 64;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [2*N-1:0] w = '0;
  logic [N-1:0]   en;
  logic           occ;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  supercell_peak_reducer #(.N_CELLS(N), .WAIT_TICKS(6)) u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .weights_i (w),
    .en_o      (en),
    .occ_o     (occ)
  );

  // row, weights driven before that row's edge, en expected after that edge
  typedef struct packed {
    logic [7:0]  row;
    logic [15:0] wt;
    logic [7:0]  ex;
  } ev_t;

  localparam ev_t EVT [21] = '{
    '{8'd1,  16'h0010, 8'h00},  // R2 cell2=1
    '{8'd7,  16'h0000, 8'h04},
    '{8'd8,  16'h0002, 8'h00},  // R4 cell0=2 opens
    '{8'd10, 16'h0804, 8'h00},  // cell5=2 tie, cell1=1 lower (R5)
    '{8'd12, 16'h0040, 8'h00},  // cell3=1 lower (R5)
    '{8'd14, 16'h8000, 8'h01},  // cell7=2 on last tick
    '{8'd16, 16'h0000, 8'h20},
    '{8'd20, 16'h0000, 8'h80},
    '{8'd22, 16'h0004, 8'h00},  // R6 cell1=1 opens
    '{8'd25, 16'h3300, 8'h00},  // cells4,6=3 restart
    '{8'd27, 16'h0030, 8'h00},  // cell2=3 tie
    '{8'd28, 16'h0008, 8'h00},  // cell1=2 lower
    '{8'd31, 16'h0003, 8'h50},  // cell0=3 last tick
    '{8'd33, 16'h0000, 8'h04},
    '{8'd37, 16'h0000, 8'h01},
    '{8'd38, 16'h0040, 8'h00},  // R7 cell3=1
    '{8'd44, 16'h0000, 8'h08},
    '{8'd45, 16'h1000, 8'h00},  // cell6=1 right after close
    '{8'd51, 16'h0000, 8'h40},
    '{8'd52, 16'hB37B, 8'h00},  // R8 R10 mixed tick
    '{8'd58, 16'h0000, 8'h55}
  };

  function automatic logic [15:0] stim_at(int r);
    stim_at = '0;
    foreach (EVT[i]) if (int'(EVT[i].row) == r) stim_at = EVT[i].wt;
  endfunction

  function automatic logic [7:0] exp_at(int r);
    exp_at = '0;
    foreach (EVT[i]) if (int'(EVT[i].row) == r) exp_at = EVT[i].ex;
  endfunction

  function automatic string tag_for(int r);
    if (r < 8)                        return "R2";
    if ((r >= 16 && r <= 19) || r == 34) return "R5";
    if (r < 22)                       return "R4";
    if (r < 38)                       return "R6";
    if (r < 52)                       return "R7";
    if (r < 59)                       return "R8,R10";
    return "R9";
  endfunction

  task automatic check(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic check_out(input logic [7:0] ex, input string tag);
    check(en === ex, tag, "en_o", 32'(en), 32'(ex));
    check(occ === (ex != 0), "R3", "occ_o", 32'(occ), 32'(ex != 0));
  endtask

  initial begin : watchdog
    repeat (5000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      n_cmp++;
      $display("FAIL watchdog: actual expired expected done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_out(8'h00, "R1");               // reset state
    rst_n = 1'b1;

    // scripted table walk
    for (int r = 0; r <= ROWS; r++) begin
      @(negedge clk);
      if (r > 0) check_out(exp_at(r-1), tag_for(r-1));
      w = (r < ROWS) ? stim_at(r) : '0;
    end

    // R1: reset in the middle of an open window discards it
    @(negedge clk);
    w = 16'h0003;
    @(negedge clk);
    w = '0;
    rst_n = 1'b0;
    check_out(8'h00, "R1");
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check_out(8'h00, "R1");
    end

    // R6: higher weight on the window's last tick restarts it
    for (int k = 0; k <= 16; k++) begin
      @(negedge clk);
      if (k > 0) check_out((k - 1 == 12) ? 8'h04 : 8'h00, "R6");
      w = (k == 0) ? 16'h0004 : (k == 6) ? 16'h0020 : 16'h0000;
    end

    finished = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule